// File: doc/BRIEF.md
# Bus-Reset Interrupt and Attach-Mode Controller

This block sits on the control side of a full-speed/low-speed USB transceiver. It takes a three-bit mode word and a high-impedance request from the host controller. From these it produces the enables for the 1.5 kΩ attach pull-up switch and for the weak charger-detect pull-up. It also produces a suspend flag and a receive-only override for the line driver.

One mode value arms a bus-reset watcher. When the single-ended-zero (SE0) indication, already synchronised to the block clock, stays high long enough, the watcher drives an active-low interrupt. The required length is longer than the low-speed SE0 filter time. Shorter SE0 pulses, such as those from low-speed differential signalling, are ignored.

The host acknowledges the interrupt by writing one of the two mode values that keep the attach pull-up on. Writing any other value also clears the interrupt and the watcher. The high-impedance request overrides everything. The deglitch length is the parameter `DEGLITCH_CYCLES`, in clock cycles. With the default of 26 cycles at 100 MHz, the length is 260 ns.

Top module: `se0_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1 and `pullup_en`, `weak_pullup_en`, `suspend_flag` and `force_rx` are 0. This is the full-speed default mode, mode word 000.
- R2: While the mode word is not 011, or `hiz` is 1, the watcher is cleared. `irq_n` reads 1 one cycle later, and a later arm needs a full new `DEGLITCH_CYCLES` run of SE0.
- R3: While armed (mode word 011, `hiz` 0), an SE0 run shorter than `DEGLITCH_CYCLES` consecutive sampled cycles leaves `irq_n` at 1. A cycle with `se0_sync` low restarts the count.
- R4: While armed, `se0_sync` high on `DEGLITCH_CYCLES` consecutive clock edges drives `irq_n` low at the last of those edges. It then stays low while the block remains armed, even after SE0 ends.
- R5: Writing mode word 010 or 110 after the interrupt sets `irq_n` back to 1 one cycle later. `pullup_en` stays 1 throughout.
- R6: `pullup_en` is 1 for mode words 010 and 110. For 011 it is 1 only once the interrupt has fired. For every other word it is 0.
- R7: `weak_pullup_en` and `force_rx` are 1 only for mode word 111. That word leaves `pullup_en` at 0.
- R8: `suspend_flag` is 1 for mode words 011, 100, 101 and 110, and 0 for 000, 001, 010 and 111.
- R9: `hiz` at 1 forces `pullup_en`, `weak_pullup_en`, `suspend_flag` and `force_rx` to 0 and `irq_n` to 1, whatever the mode word.
- R10: All outputs are registered. They reflect the inputs sampled at the most recent clock edge, one cycle of latency.

Mode word bit order: bit 2 = suspend request, bit 1 = connect request, bit 0 = speed select (0 = full speed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 3 | Mode word {suspend, connect, speed_n} |
| hiz | input | 1 | High-impedance request, overrides the mode word |
| se0_sync | input | 1 | Synchronised SE0 seen on the bus |
| irq_n | output | 1 | Active-low bus-reset interrupt |
| pullup_en | output | 1 | Close the 1.5 kΩ attach pull-up switch |
| weak_pullup_en | output | 1 | Close the weak charger-detect pull-up switch |
| suspend_flag | output | 1 | Transceiver in low-power suspend |
| force_rx | output | 1 | Hold the line driver in receive mode |

## Verification
Every output is due one clock edge after the inputs that determine it. The bench drives inputs on falling edges and compares against its reference model 2 ns after each rising edge, so each comparison sees exactly one new edge's worth of effect. The interrupt is due on the `DEGLITCH_CYCLES`-th rising edge that samples SE0 high. Directed checks count falling edges from the one where SE0 rises: after `DEGLITCH_CYCLES-1` of them `irq_n` must still be 1, and after one more it must be 0. Acknowledge, clear and high-impedance effects are checked at the first falling edge after the mode change.

// File: rtl/se0_irq_pkg.sv
// Package: shared mode-word encoding for the bus-reset interrupt controller.
// Assumes bit 2 = suspend request, bit 1 = connect request, bit 0 = speed select.
package se0_irq_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_FS_IDLE     = 3'b000,
        MODE_LS_OPEN     = 3'b001,
        MODE_FS_ATTACH   = 3'b010,
        MODE_ARM_RESET   = 3'b011,
        MODE_SUSP_OPEN   = 3'b100,
        MODE_SUSP_LS     = 3'b101,
        MODE_SUSP_ATTACH = 3'b110,
        MODE_CHARGE_DET  = 3'b111
    } mode_word_t;

endpackage

// File: rtl/se0_run_filter.sv
// Module: counts consecutive SE0 samples while armed and latches a fired flag
// once the run reaches DEGLITCH_CYCLES. Assumes se0 is already synchronous.
// The flag stays set while armed; dropping "armed" clears counter and flag.
module se0_run_filter #(
    parameter int DEGLITCH_CYCLES = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic se0,
    output logic fired
);
    localparam int CNT_W = $clog2(DEGLITCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(DEGLITCH_CYCLES - 1);

    logic [CNT_W-1:0] run_cnt;

    // Purpose: track the SE0 run length and latch the fired flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            fired   <= 1'b0;
        end else if (!armed) begin
            run_cnt <= '0;
            fired   <= 1'b0;
        end else if (!fired) begin
            if (se0) begin
                if (run_cnt == LAST_COUNT) begin
                    run_cnt <= '0;
                    fired   <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/mode_switch_decode.sv
// Module: registers the mode word and the high-impedance request, then decodes
// the switch enables, suspend flag and receive override. Assumes "fired" is
// updated on the same clock edge as the registered mode word.
module mode_switch_decode
    import se0_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              hiz_in,
    input  logic              fired,
    output logic              attach_en,
    output logic              weak_en,
    output logic              suspend,
    output logic              rx_only
);
    mode_word_t mode_q;
    logic       hiz_q;

    // Purpose: capture the mode word and the high-impedance request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FS_IDLE;
            hiz_q  <= 1'b0;
        end else begin
            mode_q <= mode_word_t'(mode_in);
            hiz_q  <= hiz_in;
        end
    end

    // Purpose: derive the switch and state outputs from the captured mode.
    always_comb begin
        attach_en = 1'b0;
        weak_en   = 1'b0;
        suspend   = 1'b0;
        rx_only   = 1'b0;
        if (!hiz_q) begin
            unique case (mode_q)
                MODE_FS_ATTACH:   attach_en = 1'b1;
                MODE_SUSP_ATTACH: begin attach_en = 1'b1; suspend = 1'b1; end
                MODE_ARM_RESET:   begin attach_en = fired; suspend = 1'b1; end
                MODE_SUSP_OPEN,
                MODE_SUSP_LS:     suspend = 1'b1;
                MODE_CHARGE_DET:  begin weak_en = 1'b1; rx_only = 1'b1; end
                default:          attach_en = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/se0_irq_ctrl.sv
// Module: top of the bus-reset interrupt and attach-mode controller.
// Arms the SE0 run filter for mode word 011 with hiz low; the interrupt is
// the registered fired flag, inverted. Assumes se0_sync is synchronised.
module se0_irq_ctrl
    import se0_irq_pkg::*;
#(
    parameter int DEGLITCH_CYCLES = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              hiz,
    input  logic              se0_sync,
    output logic              irq_n,
    output logic              pullup_en,
    output logic              weak_pullup_en,
    output logic              suspend_flag,
    output logic              force_rx
);
    logic watch_armed;
    logic reset_seen;

    // Purpose: the watcher runs only for the arm word outside high impedance.
    always_comb watch_armed = !hiz && (mode_word_t'(mode_code) == MODE_ARM_RESET);

    se0_run_filter #(
        .DEGLITCH_CYCLES(DEGLITCH_CYCLES)
    ) i_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (watch_armed),
        .se0   (se0_sync),
        .fired (reset_seen)
    );

    mode_switch_decode i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_in   (mode_code),
        .hiz_in    (hiz),
        .fired     (reset_seen),
        .attach_en (pullup_en),
        .weak_en   (weak_pullup_en),
        .suspend   (suspend_flag),
        .rx_only   (force_rx)
    );

    // Purpose: drive the active-low interrupt straight from the flag register.
    always_comb irq_n = !reset_seen;

endmodule

// File: rtl/se0_irq_ctrl_checker.sv
// Module: port-level properties of se0_irq_ctrl, bound to every instance.
module se0_irq_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_code,
    input logic       hiz,
    input logic       se0_sync,
    input logic       irq_n,
    input logic       pullup_en,
    input logic       weak_pullup_en,
    input logic       suspend_flag,
    input logic       force_rx
);
    logic armed_in;
    always_comb armed_in = !hiz && (mode_code == 3'b011);

    assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_in |=> irq_n);

    assert_fall_needs_se0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(armed_in) && $past(se0_sync)));

    assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && armed_in) |=> !irq_n);

    assert_attach_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz || mode_code == 3'b000 || mode_code == 3'b001 || mode_code == 3'b100
              || mode_code == 3'b101 || mode_code == 3'b111) |=> !pullup_en);

    assert_charge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz || mode_code != 3'b111) |=> (!weak_pullup_en && !force_rx));

    assert_hiz_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hiz |=> (irq_n && !pullup_en && !weak_pullup_en && !suspend_flag && !force_rx));

endmodule

bind se0_irq_ctrl se0_irq_ctrl_checker i_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_code      (mode_code),
    .hiz            (hiz),
    .se0_sync       (se0_sync),
    .irq_n          (irq_n),
    .pullup_en      (pullup_en),
    .weak_pullup_en (weak_pullup_en),
    .suspend_flag   (suspend_flag),
    .force_rx       (force_rx)
);

// File: tb/test_se0_irq_ctrl.sv
module test_se0_irq_ctrl;
    localparam int DG = 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_code = 3'b000;
    logic       hiz = 1'b0;
    logic       se0_sync = 1'b0;
    logic       irq_n, pullup_en, weak_pullup_en, suspend_flag, force_rx;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    int         m_run = 0;
    bit         m_fired = 1'b0;
    logic [2:0] m_mode = 3'b000;
    bit         m_hiz = 1'b0;

    se0_irq_ctrl #(.DEGLITCH_CYCLES(DG)) i_se0_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .hiz(hiz),
        .se0_sync(se0_sync), .irq_n(irq_n), .pullup_en(pullup_en),
        .weak_pullup_en(weak_pullup_en), .suspend_flag(suspend_flag),
        .force_rx(force_rx)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_fired = 0; m_mode = 3'b000; m_hiz = 0;
        end else begin
            if (hiz || mode_code != 3'b011) begin
                m_run = 0; m_fired = 0;
            end else if (!m_fired) begin
                if (se0_sync) begin
                    m_run = m_run + 1;
                    if (m_run >= DG) begin m_fired = 1; m_run = 0; end
                end else m_run = 0;
            end
            m_mode = mode_code; m_hiz = hiz;
        end
        #2;
        if (!done) begin
            check("R4 irq_n model", irq_n, !m_fired);
            check("R6 pullup model", pullup_en, !m_hiz &&
                  (m_mode == 3'b010 || m_mode == 3'b110 || (m_mode == 3'b011 && m_fired)));
            check("R7 weak model", weak_pullup_en, !m_hiz && m_mode == 3'b111);
            check("R7 force_rx model", force_rx, !m_hiz && m_mode == 3'b111);
            check("R8 suspend model", suspend_flag, !m_hiz &&
                  (m_mode == 3'b011 || m_mode[2]) && m_mode != 3'b111);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 irq_n", irq_n, 1'b1);
        check("R1 pullup", pullup_en, 1'b0);
        check("R1 weak", weak_pullup_en, 1'b0);
        check("R1 suspend", suspend_flag, 1'b0);
        check("R1 force_rx", force_rx, 1'b0);

        // R6 / R10 attach word, one cycle latency
        mode_code = 3'b010; step(1);
        check("R10 R6 pullup after one edge", pullup_en, 1'b1);
        // R8 suspend words
        for (int k = 0; k < 8; k++) begin
            mode_code = 3'(k); step(1);
            check("R8 suspend decode", suspend_flag,
                  (k == 3 || k == 4 || k == 5 || k == 6) ? 1'b1 : 1'b0);
        end
        // R7 charge detect (last loop word was 111)
        check("R7 weak on 111", weak_pullup_en, 1'b1);
        check("R7 force_rx on 111", force_rx, 1'b1);
        check("R7 no attach on 111", pullup_en, 1'b0);

        // R3 short runs while armed
        mode_code = 3'b011; step(2);
        se0_sync = 1'b1; step(DG-1);
        se0_sync = 1'b0; step(1);
        se0_sync = 1'b1; step(DG-1);
        se0_sync = 1'b0; step(1);
        check("R3 short runs ignored", irq_n, 1'b1);
        check("R6 no attach before SE0", pullup_en, 1'b0);

        // R4 exact threshold
        se0_sync = 1'b1; step(DG-1);
        check("R4 not yet at DG-1", irq_n, 1'b1);
        step(1);
        check("R4 fires at DG", irq_n, 1'b0);
        check("R6 attach after SE0", pullup_en, 1'b1);
        se0_sync = 1'b0; step(3);
        check("R4 sticky after SE0 ends", irq_n, 1'b0);

        // R5 acknowledge with 110
        mode_code = 3'b110; step(1);
        check("R5 ack releases irq", irq_n, 1'b1);
        check("R5 attach held", pullup_en, 1'b1);

        // R2 partial run cleared by a non-arm cycle
        mode_code = 3'b011; se0_sync = 1'b1; step(DG-2);
        mode_code = 3'b000; step(1);
        mode_code = 3'b011; step(DG-1);
        check("R2 count restarted", irq_n, 1'b1);
        step(1);
        check("R2 full run fires", irq_n, 1'b0);
        // R2 non-ack word clears interrupt
        mode_code = 3'b000; se0_sync = 1'b0; step(1);
        check("R2 other word clears irq", irq_n, 1'b1);
        check("R2 other word no attach", pullup_en, 1'b0);

        // R9 high impedance
        mode_code = 3'b010; hiz = 1'b1; step(1);
        check("R9 attach off", pullup_en, 1'b0);
        mode_code = 3'b111; step(1);
        check("R9 weak off", weak_pullup_en, 1'b0);
        check("R9 force_rx off", force_rx, 1'b0);
        mode_code = 3'b011; se0_sync = 1'b1; step(DG+4);
        check("R9 irq held high", irq_n, 1'b1);
        check("R9 suspend off", suspend_flag, 1'b0);
        hiz = 1'b0; step(DG-1);
        check("R9 R2 fresh run after hiz", irq_n, 1'b1);
        step(1);
        check("R4 fires after hiz release", irq_n, 1'b0);
        // R5 acknowledge with 010
        mode_code = 3'b010; se0_sync = 1'b0; step(1);
        check("R5 ack 010 releases irq", irq_n, 1'b1);
        check("R5 ack 010 attach held", pullup_en, 1'b1);

        step(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule